// File: doc/BRIEF.md
# MPPT Sample-and-Track Sequencer

This block paces a fractional open-circuit-voltage maximum power point tracker. While the tracker is enabled and the converter is qualified as active, it alternates between two phases. The long tracking phase leaves the power stage free to switch. The short sampling phase forces switching off so that the source can relax to its open-circuit voltage and a reference can be stored. With the default parameters and a 32.768 kHz timing clock, a full period lasts 16 s and the sampling window lasts about 0.4 s. The period may be set anywhere from 12 s to 20 s and the window from 0.3 s to 0.5 s, both counted in clock cycles.

A strap decode selects whether tracking is used. When the strap says tracking is off, the block never inhibits the converter. A converter-active qualifier covers start-up completion and release of under-voltage lockout. While that qualifier is low, the block parks in an idle phase with the inhibit released. The analog capture path is represented here only by the window level and by a one-cycle capture strobe.

Top module: `mppt_seq_top`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `phase` reads the tracking code 2'b01, `sw_inhibit` is 0 and `capture_stb` is 0. The cycle counter starts from zero.
- R2: With `mppt_en` and `conv_ready` both held at 1, tracking lasts PERIOD_CYCLES-SAMPLE_CYCLES clock cycles, and then `phase` changes to the sampling code 2'b10.
- R3: The sampling phase lasts exactly SAMPLE_CYCLES cycles. `sw_inhibit` is 1 for the whole phase and 0 at all other times. `phase` then returns to tracking, with the counter restarted.
- R4: `capture_stb` is 1 for exactly one cycle, the last cycle of a sampling window that completes. It is never 1 on two consecutive cycles.
- R5: While `mppt_en` is 0, `phase` stays at tracking (or idle when `conv_ready` is 0), and `sw_inhibit` is never asserted.
- R6: A change of `mppt_en` in either direction puts the block into tracking at the next edge, with the counter cleared. A following sampling phase then begins exactly PERIOD_CYCLES-SAMPLE_CYCLES cycles later.
- R7: When `conv_ready` is 0 at a clock edge, the next cycle shows the idle code 2'b00 with `sw_inhibit` at 0. When `conv_ready` returns to 1, the block enters tracking with the counter cleared.
- R8: `not_switching` is 1 throughout every sampling window, whenever the phase is idle, and whenever `conv_ready` is 0. It is 0 while tracking with `conv_ready` at 1.
- R9: If `conv_ready` falls, or `mppt_en` changes, during the last cycle of a sampling window, the window is abandoned. `capture_stb` stays 0, and the loss of the qualifier or the strap change takes priority over completing the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| mppt_en | input | 1 | Strap decode: 1 = tracking enabled, 0 = periodic deactivation suppressed |
| conv_ready | input | 1 | Converter-active qualifier (start-up done, lockout released) |
| sw_inhibit | output | 1 | Forces converter switching off; high during the sampling window |
| capture_stb | output | 1 | One-cycle strobe on the final cycle of a completed sampling window |
| not_switching | output | 1 | Converter-idle status, high during sampling, idle or without qualifier |
| phase | output | 2 | Phase code: 00 idle, 01 tracking, 10 sampling |

## Verification
The capture strobe, which completes the window, can fall in the same cycle as an abort. That abort can come from the qualifier being lost or from the strap changing. The bench counts its way into a sampling window and, on the exact final cycle, drops `conv_ready` in one run and toggles `mppt_en` in another. It then judges that the strobe stays low within that cycle, and that the following cycle shows idle or tracking, not a completed window. A behavioural model compared on every clock confirms that the counter restarts from zero afterwards.

// File: rtl/mppt_seq_pkg.sv
package mppt_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_TRACK  = 2'b01,
        PH_SAMPLE = 2'b10
    } phase_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctl_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int track_len, input int sample_len);
        int top;
        top = max_of(track_len, sample_len);
        return (top < 2) ? 1 : $clog2(top);
    endfunction

endpackage

// File: rtl/mppt_seq_timer.sv
module mppt_seq_timer
    import mppt_seq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TRACK_LAST  = 23,
    parameter int SAMPLE_LAST = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl,
    input  logic     sel_sample,
    output logic     at_end
);

    localparam logic [CNT_W-1:0] T_END   = CNT_W'(TRACK_LAST);
    localparam logic [CNT_W-1:0] S_END   = CNT_W'(SAMPLE_LAST);
    localparam logic [CNT_W-1:0] MAX_END = CNT_W'(max_of(TRACK_LAST, SAMPLE_LAST));

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
        end else if (ctl.inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        at_end = (cnt == (sel_sample ? S_END : T_END));
    end

    // R2 / R3: the shared counter never runs past the longer window
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAX_END);

    // R1: reset leaves the counter at zero
    a_r1_cnt_cleared: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0));

endmodule

// File: rtl/mppt_seq_strap.sv
module mppt_seq_strap (
    input  logic clk,
    input  logic rst,
    input  logic mppt_en,
    output logic strap_changed
);

    logic en_q;

    always_ff @(posedge clk) begin
        en_q <= mppt_en;
    end

    always_comb begin
        strap_changed = !rst && (en_q != mppt_en);
    end

    // R6: any strap edge after reset is reported in the cycle it appears
    a_r6_edge_flagged: assert property (@(posedge clk) disable iff (rst)
        (mppt_en != $past(mppt_en)) |-> strap_changed);

endmodule

// File: rtl/mppt_seq_fsm.sv
module mppt_seq_fsm
    import mppt_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     conv_ready,
    input  logic     mppt_en,
    input  logic     strap_changed,
    input  logic     at_end,
    output phase_e   phase,
    output cnt_ctl_t ctl,
    output logic     sample_last
);

    phase_e nxt;

    always_comb begin
        nxt = phase;
        ctl = '{clr: 1'b0, inc: 1'b0};
        if (!conv_ready) begin
            nxt     = PH_IDLE;
            ctl.clr = 1'b1;
        end else if (strap_changed || !mppt_en) begin
            nxt     = PH_TRACK;
            ctl.clr = 1'b1;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    nxt     = PH_TRACK;
                    ctl.clr = 1'b1;
                end
                PH_TRACK: begin
                    if (at_end) begin
                        nxt     = PH_SAMPLE;
                        ctl.clr = 1'b1;
                    end else begin
                        ctl.inc = 1'b1;
                    end
                end
                PH_SAMPLE: begin
                    if (at_end) begin
                        nxt     = PH_TRACK;
                        ctl.clr = 1'b1;
                    end else begin
                        ctl.inc = 1'b1;
                    end
                end
                default: begin
                    nxt     = PH_IDLE;
                    ctl.clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_TRACK;
        end else begin
            phase <= nxt;
        end
    end

    always_comb begin
        sample_last = (phase == PH_SAMPLE) && at_end && conv_ready
                      && mppt_en && !strap_changed;
    end

    // R2: a sampling window opens only off the end of a tracking count
    a_r2_sample_from_end: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_SAMPLE) |-> $past(at_end));

    // R3: a completed window always hands back to tracking
    a_r3_window_closes: assert property (@(posedge clk) disable iff (rst)
        ($past(phase == PH_SAMPLE) && $past(at_end) && $past(conv_ready)
         && $past(mppt_en) && !$past(strap_changed)) |-> (phase == PH_TRACK));

endmodule

// File: rtl/mppt_seq_top.sv
module mppt_seq_top
    import mppt_seq_pkg::*;
#(
    parameter int PERIOD_CYCLES = 524288,
    parameter int SAMPLE_CYCLES = 13107
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mppt_en,
    input  logic       conv_ready,
    output logic       sw_inhibit,
    output logic       capture_stb,
    output logic       not_switching,
    output logic [1:0] phase
);

    localparam int TRACK_CYCLES = PERIOD_CYCLES - SAMPLE_CYCLES;
    localparam int CNT_W        = cnt_width(TRACK_CYCLES, SAMPLE_CYCLES);

    phase_e   cur_phase;
    cnt_ctl_t ctl;
    logic     at_end;
    logic     strap_changed;
    logic     sample_last;

    mppt_seq_strap u_strap (
        .clk           (clk),
        .rst           (rst),
        .mppt_en       (mppt_en),
        .strap_changed (strap_changed)
    );

    mppt_seq_timer #(
        .CNT_W       (CNT_W),
        .TRACK_LAST  (TRACK_CYCLES - 1),
        .SAMPLE_LAST (SAMPLE_CYCLES - 1)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .sel_sample (cur_phase == PH_SAMPLE),
        .at_end     (at_end)
    );

    mppt_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .conv_ready    (conv_ready),
        .mppt_en       (mppt_en),
        .strap_changed (strap_changed),
        .at_end        (at_end),
        .phase         (cur_phase),
        .ctl           (ctl),
        .sample_last   (sample_last)
    );

    always_comb begin
        sw_inhibit    = (cur_phase == PH_SAMPLE);
        capture_stb   = sample_last;
        not_switching = (cur_phase != PH_TRACK) || !conv_ready;
        phase         = cur_phase;
    end

    // R5: with the strap off the converter is never held idle
    a_r5_no_inhibit_off: assert property (@(posedge clk) disable iff (rst)
        !mppt_en |=> !sw_inhibit);

    // R7: losing the qualifier parks the block in idle with inhibit released
    a_r7_idle_on_drop: assert property (@(posedge clk) disable iff (rst)
        !conv_ready |=> (phase == 2'b00) && !sw_inhibit);

    // R4: the capture strobe is a single cycle wide
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        capture_stb |=> !capture_stb);

    // R4: the strobe only occurs inside a sampling window, which then closes
    a_r4_strobe_closes: assert property (@(posedge clk) disable iff (rst)
        capture_stb |-> sw_inhibit ##1 (phase == 2'b01));

    // R8: the idle status flag covers the whole window
    a_r8_flag_in_window: assert property (@(posedge clk) disable iff (rst)
        sw_inhibit |-> not_switching);

    // R9: no capture while the qualifier is missing
    a_r9_no_strobe_unqualified: assert property (@(posedge clk) disable iff (rst)
        !conv_ready |-> !capture_stb);

endmodule

// File: tb/mppt_seq_top_bench.sv
module mppt_seq_top_bench;

    localparam int PERIOD = 30;
    localparam int SAMPLE = 6;
    localparam int TRACK  = PERIOD - SAMPLE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mppt_en = 1'b1;
    logic       conv_ready = 1'b1;
    logic       sw_inhibit;
    logic       capture_stb;
    logic       not_switching;
    logic [1:0] phase;

    int checks = 0;
    int failures = 0;

    // behavioural reference: 0 idle, 1 tracking, 2 sampling
    int m_phase = 1;
    int m_cnt = 0;
    logic m_en_prev = 1'b1;

    always #2 clk = ~clk;

    mppt_seq_top #(
        .PERIOD_CYCLES (PERIOD),
        .SAMPLE_CYCLES (SAMPLE)
    ) u_mppt_seq_top (
        .clk           (clk),
        .rst           (rst),
        .mppt_en       (mppt_en),
        .conv_ready    (conv_ready),
        .sw_inhibit    (sw_inhibit),
        .capture_stb   (capture_stb),
        .not_switching (not_switching),
        .phase         (phase)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_phase   <= 1;
            m_cnt     <= 0;
            m_en_prev <= mppt_en;
        end else begin
            m_en_prev <= mppt_en;
            if (!conv_ready) begin
                m_phase <= 0; m_cnt <= 0;
            end else if (mppt_en != m_en_prev || !mppt_en) begin
                m_phase <= 1; m_cnt <= 0;
            end else if (m_phase == 0) begin
                m_phase <= 1; m_cnt <= 0;
            end else if (m_phase == 1) begin
                if (m_cnt == TRACK - 1) begin m_phase <= 2; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end else begin
                if (m_cnt == SAMPLE - 1) begin m_phase <= 1; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        int exp_cap;
        exp_cap = (m_phase == 2 && m_cnt == SAMPLE - 1 && conv_ready
                   && mppt_en == m_en_prev && mppt_en) ? 1 : 0;
        check("R2 phase vs model", int'(phase), m_phase);
        check("R3 inhibit vs model", int'(sw_inhibit), (m_phase == 2) ? 1 : 0);
        check("R4 capture vs model", int'(capture_stb), exp_cap);
        check("R8 not_switching vs model", int'(not_switching),
              (m_phase != 1 || !conv_ready) ? 1 : 0);
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) compare_model();
    endtask

    task automatic wait_window_start();
        for (int g = 0; g < 200 && sw_inhibit; g++) tick();
        for (int g = 0; g < 200 && !sw_inhibit; g++) tick();
        check("R3 window reached", int'(sw_inhibit), 1);
    endtask

    initial begin
        int n;
        int seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset phase", int'(phase), 1);
        check("R1 reset inhibit", int'(sw_inhibit), 0);
        check("R1 reset capture", int'(capture_stb), 0);
        rst = 1'b0;

        // R1 / R2: first sampling window opens TRACK cycles after reset
        n = 0;
        for (int g = 0; g < 200 && !sw_inhibit; g++) begin tick(); n++; end
        check("R2 track length after reset", n, TRACK);

        // R3: window width
        n = 0;
        for (int g = 0; g < 200 && sw_inhibit; g++) begin
            if (capture_stb) check("R4 strobe on last cycle", n, SAMPLE - 1);
            tick(); n++;
        end
        check("R3 window length", n, SAMPLE);
        repeat (2 * PERIOD) tick();

        // R5: strap off suppresses the inhibit entirely
        mppt_en = 1'b0;
        seen = 0;
        for (int i = 0; i < 3 * PERIOD; i++) begin tick(); if (sw_inhibit) seen++; end
        check("R5 inhibit cycles while disabled", seen, 0);
        check("R5 phase while disabled", int'(phase), 1);

        // R6: strap change restarts tracking from zero
        mppt_en = 1'b1;
        tick();
        check("R6 phase after enable", int'(phase), 1);
        wait_window_start();
        mppt_en = 1'b0;
        tick();
        check("R6 phase after strap drop mid-window", int'(phase), 1);
        check("R6 inhibit after strap drop", int'(sw_inhibit), 0);
        mppt_en = 1'b1;
        tick();
        n = 0;
        for (int g = 0; g < 200 && !sw_inhibit; g++) begin tick(); n++; end
        check("R6 track length after strap change", n, TRACK);

        // R7: qualifier loss mid-window
        tick();
        conv_ready = 1'b0;
        #1 check("R8 flag with qualifier low", int'(not_switching), 1);
        tick();
        check("R7 idle phase", int'(phase), 0);
        check("R7 inhibit released", int'(sw_inhibit), 0);
        repeat (4) tick();
        conv_ready = 1'b1;
        n = 0;
        for (int g = 0; g < 200 && !sw_inhibit; g++) begin tick(); n++; end
        check("R7 cycles to window after recovery", n, TRACK + 1);

        // R9: qualifier drops on the final window cycle
        repeat (SAMPLE - 1) tick();
        check("R4 strobe before abort test", int'(capture_stb), 1);
        wait_window_start();
        repeat (SAMPLE - 1) tick();
        conv_ready = 1'b0;
        #1 check("R9 no strobe on qualifier drop", int'(capture_stb), 0);
        tick();
        check("R9 idle after abort", int'(phase), 0);
        conv_ready = 1'b1;

        // R9: strap toggles on the final window cycle
        wait_window_start();
        repeat (SAMPLE - 1) tick();
        mppt_en = 1'b0;
        #1 check("R9 no strobe on strap change", int'(capture_stb), 0);
        tick();
        check("R9 tracking after strap abort", int'(phase), 1);
        mppt_en = 1'b1;
        repeat (2 * PERIOD) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule